// File: doc/BRIEF.md
# Dual-Rail Handshake Stage Register

This block is the storage front end of one self-timed pipeline stage. Each logical bit travels on a true rail and a false rail. A one is (true=1, false=0) and a zero is (true=0, false=1). Both rails low is the spacer, and both rails high is never used. Words arrive under a four-phase return-to-zero handshake: a codeword, then a spacer, then the next codeword, and so on. There is no clock.

Every rail passes through its own state-holding two-input C-element. The other input of each C-element is the stage acknowledge input `ack_i`. That input is the inverted acknowledge of the downstream stage, so it is high when the next stage is ready for a new codeword and low when the next stage wants a spacer. A C-element output rises only when both of its inputs are 1, falls only when both are 0, and otherwise keeps its value.

A completion detector watches the registered word. It ORs the two rails of each bit, then joins the results through a balanced tree of two-input C-elements. The result is `ack_o`, which goes to the upstream sender. An upstream sender waits for `ack_o` to rise before it returns its bus to spacer, and waits for `ack_o` to fall before it sends the next codeword.

Top module: `dr_stage_reg`

## Requirements
- R1: While `rst_ni` is low, every output rail and `ack_o` are 0, whatever the inputs. Reset takes effect without waiting for any event.
- R2: With `ack_i` high, a valid codeword on the inputs appears on the outputs. `data_t_o` equals the input true rails and `data_f_o` equals the input false rails.
- R3: No output bit ever shows both rails high.
- R4: With `ack_i` high, returning the inputs to spacer leaves the registered codeword and `ack_o` unchanged.
- R5: With `ack_i` low and the inputs at spacer, all output rails go to 0 and `ack_o` falls.
- R6: `ack_o` stays low while any output bit is still spacer. It rises once every bit holds a valid code.
- R7: `ack_o` stays high while any output bit still holds a valid code. It falls once every bit is spacer.
- R8: With `ack_i` low, a codeword on the inputs does not reach the outputs, which stay at spacer. When `ack_i` later rises, the codeword passes.
- R9: A sequence of words sent under the full four-phase handshake, with the environment as both sender and receiver, is delivered in order. Each word is delivered unchanged, and none is overwritten before the receiver acknowledges it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous reset; clears all C-elements |
| data_t_i | input | W | True rails of the incoming dual-rail word |
| data_f_i | input | W | False rails of the incoming dual-rail word |
| ack_i | input | 1 | Inverted downstream acknowledge: 1 admits codewords, 0 admits spacer |
| data_t_o | output | W | True rails of the registered word |
| data_f_o | output | W | False rails of the registered word |
| ack_o | output | 1 | Completion acknowledge to upstream: 1 when the word is full, 0 when it is spacer |

## Verification
The checker watches every change on the output rails. It checks that no bit shows both rails high (R3). It checks that a rail rises only while `ack_i` is high and falls only while `ack_i` is low (R8, R4). At each edge of `ack_o` it checks that the word is completely valid on a rise (R6) and completely spacer on a fall (R7). Only the bench scenarios can show the rest. Those are arrival and departure one bit at a time, holding a codeword while the input returns to spacer, blocking an early codeword, an asynchronous reset in the middle of a word, and ordered delivery of a stream of words through a real handshake with sender and receiver.

// File: rtl/dr_stage_pkg.sv
package dr_stage_pkg;
  localparam int unsigned DR_DEFAULT_W = 33;

  // leaves of the completion tree: width rounded up to a power of two
  function automatic int unsigned dr_tree_leaves(input int unsigned n);
    return (n <= 1) ? 1 : (1 << $clog2(n));
  endfunction
endpackage

// File: rtl/dr_cgate.sv
module dr_cgate (
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic z_o
);
  // behavioural two-input C-element: follows inputs when they agree, else holds
  always_latch begin
    if (!rst_ni)        z_o <= 1'b0;
    else if (a_i == b_i) z_o <= a_i;
  end
endmodule

// File: rtl/dr_rail_bank.sv
module dr_rail_bank #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  input  logic         en_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] f_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    dr_cgate u_t (.rst_ni(rst_ni), .a_i(t_i[b]), .b_i(en_i), .z_o(t_o[b]));
    dr_cgate u_f (.rst_ni(rst_ni), .a_i(f_i[b]), .b_i(en_i), .z_o(f_o[b]));
  end
endmodule

// File: rtl/dr_done_tree.sv
module dr_done_tree #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  output logic         done_o
);
  import dr_stage_pkg::*;
  localparam int unsigned P = dr_tree_leaves(W);

  logic [W-1:0]     any_v;
  logic [2*P-1:1]   node;   // heap order: node[1] is the root

  assign any_v = t_i | f_i;

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < W) begin : g_real
      assign node[P+k] = any_v[k];
    end else begin : g_pad
      assign node[P+k] = any_v[0];  // padding repeats a real leaf, keeps C-gates balanced
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_node
    dr_cgate u_c (.rst_ni(rst_ni), .a_i(node[2*i]), .b_i(node[2*i+1]), .z_o(node[i]));
  end

  assign done_o = node[1];
endmodule

// File: rtl/dr_stage_reg.sv
module dr_stage_reg #(
  parameter int unsigned W = dr_stage_pkg::DR_DEFAULT_W
) (
  input  logic         rst_ni,
  input  logic [W-1:0] data_t_i,
  input  logic [W-1:0] data_f_i,
  input  logic         ack_i,
  output logic [W-1:0] data_t_o,
  output logic [W-1:0] data_f_o,
  output logic         ack_o
);
  dr_rail_bank #(.W(W)) u_bank (
    .rst_ni(rst_ni),
    .t_i   (data_t_i),
    .f_i   (data_f_i),
    .en_i  (ack_i),
    .t_o   (data_t_o),
    .f_o   (data_f_o)
  );

  dr_done_tree #(.W(W)) u_done (
    .rst_ni(rst_ni),
    .t_i   (data_t_o),
    .f_i   (data_f_o),
    .done_o(ack_o)
  );
endmodule

// File: rtl/dr_stage_reg_chk.sv
module dr_stage_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_ni,
  input logic         ack_i,
  input logic [W-1:0] data_t_o,
  input logic [W-1:0] data_f_o,
  input logic         ack_o
);
  logic [2*W-1:0] prev_rails;

  always @(data_t_o or data_f_o or rst_ni) begin
    if (!rst_ni) begin
      prev_rails = '0;
    end else begin
      a_r3_no_both_rails: assert ((data_t_o & data_f_o) == '0)
        else $error("R3: both rails high");
      a_r8_rise_needs_ack: assert ((({data_t_o, data_f_o} & ~prev_rails) == '0) || ack_i)
        else $error("R8: rail rose with ack_i low");
      a_r4_fall_needs_release: assert (((prev_rails & ~{data_t_o, data_f_o}) == '0) || !ack_i)
        else $error("R4: rail fell with ack_i high");
      prev_rails = {data_t_o, data_f_o};
    end
  end

  always @(posedge ack_o) begin
    if (rst_ni) begin
      a_r6_ack_rise_full: assert ((data_t_o | data_f_o) == {W{1'b1}})
        else $error("R6: ack rose on partial word");
    end
  end

  always @(negedge ack_o) begin
    if (rst_ni) begin
      a_r7_ack_fall_empty: assert ((data_t_o | data_f_o) == '0)
        else $error("R7: ack fell before full spacer");
    end
  end
endmodule

bind dr_stage_reg dr_stage_reg_chk #(.W(W)) u_chk (
  .rst_ni  (rst_ni),
  .ack_i   (ack_i),
  .data_t_o(data_t_o),
  .data_f_o(data_f_o),
  .ack_o   (ack_o)
);

// File: tb/dr_stage_reg_test.sv
`timescale 1ns/1ps
module dr_stage_reg_test;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [W-1:0] din_t, din_f;
  logic         ack_i;
  logic [W-1:0] dout_t, dout_f;
  logic         ack_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;
  logic [W-1:0] exp_q[$];
  int unsigned  n_sent = 0;
  int unsigned  n_seen = 0;
  bit           sb_on = 1'b0;

  always #5 clk = ~clk;

  dr_stage_reg #(.W(W)) uut (
    .rst_ni  (rst_ni),
    .data_t_i(din_t),
    .data_f_i(din_f),
    .ack_i   (ack_i),
    .data_t_o(dout_t),
    .data_f_o(dout_f),
    .ack_o   (ack_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic put_word(input logic [W-1:0] w);
    din_t = w;
    din_f = ~w;
  endtask

  task automatic put_spacer();
    din_t = '0;
    din_f = '0;
  endtask

  // upstream sender: waits for ack_o low, sends, waits for ack_o high, returns to spacer
  task automatic send_word(input logic [W-1:0] w);
    do @(posedge clk); while (ack_o);
    exp_q.push_back(w);
    n_sent++;
    put_word(w);
    do @(posedge clk); while (!ack_o);
    put_spacer();
  endtask

  // downstream receiver and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_on && ack_o) begin
        logic [W-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
        n_seen++;
        check("R9 word order", {24'd0, dout_t}, {24'd0, e});
        check("R9 false rails", {24'd0, dout_f}, {24'd0, ~e});
        @(negedge clk);
        check("R9 held until acknowledged", {24'd0, dout_t}, {24'd0, e});
        check("R3 no both rails", {24'd0, dout_t & dout_f}, 32'd0);
        @(posedge clk) ack_i = 1'b0;
        do @(negedge clk); while (ack_o);
        check("R5 spacer after release", {24'd0, dout_t | dout_f}, 32'd0);
        @(posedge clk) ack_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] w;
    rst_ni = 1'b0;
    ack_i  = 1'b1;
    put_word(8'hA5);               // valid data during reset must not pass
    @(negedge clk);
    check("R1 reset true rails", {24'd0, dout_t}, 32'd0);
    check("R1 reset false rails", {24'd0, dout_f}, 32'd0);
    check("R1 reset ack", {31'd0, ack_o}, 32'd0);
    @(posedge clk) put_spacer();
    @(posedge clk) rst_ni = 1'b1;

    // R6: bits arrive one at a time
    w = 8'h6C;
    for (int b = 0; b < W; b++) begin
      @(posedge clk);
      din_t[b] = w[b];
      din_f[b] = ~w[b];
      @(negedge clk);
      check("R6 ack vs arrival", {31'd0, ack_o}, (b == W-1) ? 32'd1 : 32'd0);
    end
    check("R2 pass true rails", {24'd0, dout_t}, {24'd0, w});
    check("R2 pass false rails", {24'd0, dout_f}, {24'd0, ~w});

    // R4: input back to spacer while ack_i high
    @(posedge clk) put_spacer();
    @(negedge clk);
    check("R4 codeword held", {24'd0, dout_t}, {24'd0, w});
    check("R4 ack held", {31'd0, ack_o}, 32'd1);

    // R5: release
    @(posedge clk) ack_i = 1'b0;
    @(negedge clk);
    check("R5 outputs spacer", {24'd0, dout_t | dout_f}, 32'd0);
    check("R5 ack low", {31'd0, ack_o}, 32'd0);

    // R8: early codeword blocked while ack_i low
    @(posedge clk) put_word(8'h3B);
    @(negedge clk);
    check("R8 blocked", {24'd0, dout_t | dout_f}, 32'd0);
    check("R8 ack low", {31'd0, ack_o}, 32'd0);
    @(posedge clk) ack_i = 1'b1;
    @(negedge clk);
    check("R8 passes after ack", {24'd0, dout_t}, 32'h3B);
    check("R2 ack after full", {31'd0, ack_o}, 32'd1);

    // R7: bits leave one at a time
    @(posedge clk) ack_i = 1'b0;
    for (int b = 0; b < W; b++) begin
      @(posedge clk);
      din_t[b] = 1'b0;
      din_f[b] = 1'b0;
      @(negedge clk);
      check("R7 ack vs departure", {31'd0, ack_o}, (b == W-1) ? 32'd0 : 32'd1);
    end

    // R1: asynchronous reset in the middle of a held word
    @(posedge clk) ack_i = 1'b1;
    put_word(8'hF0);
    @(negedge clk);
    check("R2 word before reset", {24'd0, dout_f}, 32'h0F);
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async clear", {24'd0, dout_t | dout_f}, 32'd0);
    check("R1 async ack", {31'd0, ack_o}, 32'd0);
    put_spacer();
    @(posedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check("R1 stays clear", {24'd0, dout_t | dout_f}, 32'd0);

    // R9: stream under full handshake
    sb_on = 1'b1;
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'h5A);
    send_word(8'h81);
    for (int i = 0; i < 12; i++) send_word(8'((i * 37 + 11) & 8'hFF));
    repeat (20) @(posedge clk);
    check("R9 all delivered", n_seen, n_sent);
    check("R9 queue empty", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule